// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Responder

This block is the device side of an interrupt scheme in which four request levels (4 through 7) share one acknowledge line that is daisy-chained from slot to slot. A pulse on the local request input is latched and shown on the one request line that matches the configured level. The processor raises its read strobe, with sync negated, well before it raises the acknowledge. The block makes its arbitration decision at that strobe edge. When the acknowledge arrives, the block passes it downstream if the decision went against it. If the decision went in its favour, it answers with reply and its vector. It drops both when the acknowledge goes away.

All bus inputs pass through a synchronizer whose depth is a parameter. The arbitration flop samples only on the read-strobe edge, and its output is used only once the later acknowledge arrives. Any settling of that flop therefore has a full strobe-to-acknowledge window in which to finish. Beyond that, the vector response is plain gating on the acknowledge.

The controller has four states. IDLE means nothing is pending. REQUESTING means a request is latched and its line is driven. PRESENTING means reply and the vector are driven. PRESENTING_HELD is PRESENTING with a newer local request held back. The transitions are named as follows:
- `latch`: IDLE to REQUESTING, on a local request edge.
- `win`: REQUESTING to PRESENTING, when the acknowledge arrives while the arbitration flop is set.
- `release`: PRESENTING to IDLE, when the acknowledge drops.
- `hold`: PRESENTING to PRESENTING_HELD, on a local request edge during presentation.
- `rearm`: PRESENTING_HELD to REQUESTING, when the acknowledge drops. A local request edge that arrives in the same cycle as the acknowledge drops in PRESENTING also leads to REQUESTING.
- `init`: from any state to IDLE, on bus init.

Top module: `iak_responder`

## Requirements
- R1: After reset, and after bus init, req_line is 0, iack_out is 0, reply and vec_sel are 0 and vec_data is 0. Bus init also discards a latched request and clears the arbitration flop, so a later acknowledge is forwarded.
- R2: A rising edge on local_req latches a request. req_line then has exactly bit cfg_level set, where cfg_level 0..3 stands for levels 4..7. All other bits stay 0.
- R3: On each rising edge of rd_strobe, the arbitration flop is set only if a request is latched and no lvl_lines bit above index cfg_level is 1. Otherwise it is cleared. Lines at or below the configured level do not block.
- R4: iack_out follows the synchronized iack_in, except that it is held at 0 while the arbitration flop is set.
- R5: When the acknowledge arrives with the flop set, reply and vec_sel go to 1, vec_data equals cfg_vector, and req_line returns to 0.
- R6: When iack_in drops, reply and vec_sel return to 0 and vec_data returns to 0.
- R7: The level of sync_in has no effect on arbitration or on the response.
- R8: After a service, the next rising edge of rd_strobe clears the arbitration flop, so the following acknowledge is forwarded.
- R9: A local_req edge that arrives while the vector is being presented does not assert req_line until iack_in drops. After that, the request is driven again and can win a later arbitration.
- R10: A request latched after rd_strobe has already risen does not take part in that arbitration. The acknowledge that follows is forwarded, and the request line stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_init | input | 1 | Bus initialize, synchronized, clears the block |
| local_req | input | 1 | Device interrupt request, rising edge latched |
| rd_strobe | input | 1 | Received read strobe, arbitration edge |
| sync_in | input | 1 | Received sync, not used for the decision |
| iack_in | input | 1 | Incoming daisy-chained acknowledge |
| lvl_lines | input | NUM_LEVELS | Received request lines, bit i = level 4+i |
| cfg_level | input | LVL_W | Configured level index |
| cfg_vector | input | VEC_W | Interrupt vector to present |
| req_line | output | NUM_LEVELS | Request lines driven by this device |
| iack_out | output | 1 | Outgoing acknowledge to the next slot |
| reply | output | 1 | Reply while presenting the vector |
| vec_sel | output | 1 | Selects the vector onto the data lines |
| vec_data | output | VEC_W | Vector data, 0 when not selected |

## Verification
The bench sweeps every configured level against every pattern of the four level lines, with and without a local request, and with sync toggled across the sweep. It computes the winner from the shift of the pattern above the configured level. A priority mask off by one would block on the device's own line, or would let a higher line through, and would answer or forward on the wrong cases. Directed cases cover a stale arbitration flop that blocks every acknowledge after one service, a request raised during presentation that is either lost or driven too early, a request that arrives after the strobe and wrongly wins, and an init that fails to drop a pending request.

// File: rtl/iak_pkg.sv
package iak_pkg;

    localparam int NUM_LEVELS = 4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ       = 2'd1,
        ST_PRES      = 2'd2,
        ST_PRES_HELD = 2'd3
    } iak_state_t;

endpackage

// File: rtl/iak_sync.sv
module iak_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/iak_prio.sv
module iak_prio #(
    parameter int NUM_LEVELS = 4,
    parameter int LVL_W      = 2
) (
    input  logic [NUM_LEVELS-1:0] lvl_lines,
    input  logic [LVL_W-1:0]      cfg_level,
    output logic                  higher
);

    logic [NUM_LEVELS-1:0] above;

    generate
        for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_mask
            assign above[g] = (cfg_level < LVL_W'(g));
        end
    endgenerate

    assign higher = |(lvl_lines & above);

endmodule

// File: rtl/iak_responder.sv
module iak_responder
    import iak_pkg::*;
#(
    parameter int VEC_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_W       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_init,
    input  logic                  local_req,
    input  logic                  rd_strobe,
    input  logic                  sync_in,
    input  logic                  iack_in,
    input  logic [NUM_LEVELS-1:0] lvl_lines,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic [VEC_W-1:0]      cfg_vector,
    output logic [NUM_LEVELS-1:0] req_line,
    output logic                  iack_out,
    output logic                  reply,
    output logic                  vec_sel,
    output logic [VEC_W-1:0]      vec_data
);

    localparam int IN_W = 5 + NUM_LEVELS;

    logic [IN_W-1:0]       raw_in;
    logic [IN_W-1:0]       syn_in;
    logic                  init_s;
    logic                  lreq_s;
    logic                  rd_s;
    logic                  sync_s;
    logic                  iack_s;
    logic [NUM_LEVELS-1:0] lvl_s;

    assign raw_in = {bus_init, local_req, rd_strobe, sync_in, iack_in, lvl_lines};

    iak_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {init_s, lreq_s, rd_s, sync_s, iack_s, lvl_s} = syn_in;

    logic lreq_d;
    logic rd_d;
    logic req_rise;
    logic rd_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lreq_d <= 1'b0;
            rd_d   <= 1'b0;
        end else begin
            lreq_d <= lreq_s;
            rd_d   <= rd_s;
        end
    end

    assign req_rise = lreq_s & ~lreq_d;
    assign rd_rise  = rd_s & ~rd_d;

    logic higher;

    iak_prio #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_prio (
        .lvl_lines (lvl_s),
        .cfg_level (cfg_level),
        .higher    (higher)
    );

    iak_state_t state;
    iak_state_t state_nx;
    logic       mine;

    // Arbitration flop: decided only at the read-strobe edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mine <= 1'b0;
        end else if (init_s) begin
            mine <= 1'b0;
        end else if (rd_rise) begin
            mine <= (state == ST_REQ) && !higher;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (init_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_rise) state_nx = ST_REQ;
                end
                ST_REQ: begin
                    if (iack_s && mine) state_nx = ST_PRES;
                end
                ST_PRES: begin
                    if (!iack_s) state_nx = req_rise ? ST_REQ : ST_IDLE;
                    else if (req_rise) state_nx = ST_PRES_HELD;
                end
                ST_PRES_HELD: begin
                    if (!iack_s) state_nx = ST_REQ;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs
    logic [NUM_LEVELS-1:0] lvl_onehot;

    generate
        for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_onehot
            assign lvl_onehot[g] = (cfg_level == LVL_W'(g));
        end
    endgenerate

    always_comb begin
        req_line = '0;
        reply    = 1'b0;
        vec_sel  = 1'b0;
        vec_data = '0;
        unique case (state)
            ST_IDLE: ;
            ST_REQ: req_line = lvl_onehot;
            ST_PRES, ST_PRES_HELD: begin
                reply    = 1'b1;
                vec_sel  = 1'b1;
                vec_data = cfg_vector;
            end
            default: ;
        endcase
    end

    assign iack_out = iack_s & ~mine;

    // Assertions
    assert_one_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_line));

    assert_no_pass_in_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reply |-> !iack_out);

    assert_line_low_in_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reply |-> (req_line == '0));

    assert_reply_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reply && !iack_s && !init_s && state == ST_PRES && !req_rise) |=> !reply);

    assert_mine_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_rise && !init_s) |=> $stable(mine));

    assert_sync_no_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && sync_s && !init_s && state == ST_REQ && !higher) |=> mine);

    assert_held_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRES_HELD && !iack_s && !init_s) |=> (state == ST_REQ));

endmodule

// File: tb/sim_iak_responder.sv
`timescale 1ns/100ps
module sim_iak_responder;

    localparam int VW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_init = 1'b0;
    logic          local_req = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          sync_in = 1'b0;
    logic          iack_in = 1'b0;
    logic [3:0]    lvl_lines = '0;
    logic [1:0]    cfg_level = '0;
    logic [VW-1:0] cfg_vector = '0;
    logic [3:0]    req_line;
    logic          iack_out;
    logic          reply;
    logic          vec_sel;
    logic [VW-1:0] vec_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    iak_responder u0 (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .local_req(local_req),
        .rd_strobe(rd_strobe), .sync_in(sync_in), .iack_in(iack_in),
        .lvl_lines(lvl_lines), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
        .req_line(req_line), .iack_out(iack_out), .reply(reply),
        .vec_sel(vec_sel), .vec_data(vec_data)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_init();
        bus_init = 1'b1; wt(4);
        bus_init = 1'b0; wt(6);
    endtask

    task automatic pulse_req();
        local_req = 1'b1; wt(4);
        local_req = 1'b0; wt(6);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        wt(3);
        rst_n = 1'b1;
        wt(4);
        // R1 reset state
        chk("R1 req_line", 32'(req_line), 0);
        chk("R1 iack_out", 32'(iack_out), 0);
        chk("R1 reply", 32'(reply), 0);
        chk("R1 vec_data", 32'(vec_data), 0);

        // Sweep: level x line pattern x request (R2 R3 R4 R5 R6 R7)
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int pat = 0; pat < 16; pat++) begin
                for (int rq = 0; rq < 2; rq++) begin
                    logic win;
                    logic [3:0] lvl_exp;
                    do_init();
                    cfg_level  = 2'(cfg);
                    cfg_vector = 16'h0100 + 16'(cfg * 16 + pat);
                    if (rq == 1) pulse_req();
                    lvl_exp = (rq == 1) ? 4'(1 << cfg) : 4'h0;
                    chk("R2 req_line", 32'(req_line), 32'(lvl_exp));
                    win = (rq == 1) && ((pat >> (cfg + 1)) == 0);
                    lvl_lines = 4'(pat);
                    sync_in   = 1'(pat ^ cfg);
                    rd_strobe = 1'b1; wt(8);
                    iack_in   = 1'b1; wt(8);
                    chk("R3 R7 iack_out", 32'(iack_out), 32'(!win));
                    chk("R5 reply", 32'(reply), 32'(win));
                    chk("R5 vec_sel", 32'(vec_sel), 32'(win));
                    chk("R5 vec_data", 32'(vec_data), win ? 32'(cfg_vector) : 0);
                    chk("R5 req_line", 32'(req_line), win ? 0 : 32'(lvl_exp));
                    iack_in = 1'b0; wt(8);
                    chk("R6 reply", 32'(reply), 0);
                    chk("R6 vec_data", 32'(vec_data), 0);
                    chk("R4 iack_out low", 32'(iack_out), 0);
                    rd_strobe = 1'b0; lvl_lines = '0; sync_in = 1'b0; wt(4);
                end
            end
        end

        // R8: next strobe after service clears the flop
        do_init();
        cfg_level = 2'd2; cfg_vector = 16'h00C4;
        pulse_req();
        rd_strobe = 1'b1; wt(8); iack_in = 1'b1; wt(8);
        chk("R8 first win reply", 32'(reply), 1);
        iack_in = 1'b0; wt(8); rd_strobe = 1'b0; wt(6);
        rd_strobe = 1'b1; wt(8); iack_in = 1'b1; wt(8);
        chk("R8 forwarded", 32'(iack_out), 1);
        chk("R8 no reply", 32'(reply), 0);
        iack_in = 1'b0; wt(6); rd_strobe = 1'b0; wt(6);

        // R9: request during presentation held and re-raised
        do_init();
        cfg_level = 2'd1; cfg_vector = 16'h0070;
        pulse_req();
        rd_strobe = 1'b1; wt(8); iack_in = 1'b1; wt(8);
        chk("R9 presenting", 32'(reply), 1);
        pulse_req();
        chk("R9 held line", 32'(req_line), 0);
        chk("R9 still reply", 32'(reply), 1);
        iack_in = 1'b0; wt(8);
        chk("R9 re-raised", 32'(req_line), 32'h2);
        rd_strobe = 1'b0; wt(6);
        rd_strobe = 1'b1; wt(8); iack_in = 1'b1; wt(8);
        chk("R9 wins again", 32'(reply), 1);
        chk("R9 vector", 32'(vec_data), 32'h0070);
        iack_in = 1'b0; wt(6); rd_strobe = 1'b0; wt(6);

        // R10: request after strobe does not win
        do_init();
        cfg_level = 2'd3;
        rd_strobe = 1'b1; wt(8);
        pulse_req();
        iack_in = 1'b1; wt(8);
        chk("R10 forwarded", 32'(iack_out), 1);
        chk("R10 no reply", 32'(reply), 0);
        chk("R10 line kept", 32'(req_line), 32'h8);
        iack_in = 1'b0; wt(6); rd_strobe = 1'b0; wt(6);

        // R1: init discards a pending request and the flop
        do_init();
        cfg_level = 2'd0;
        pulse_req();
        rd_strobe = 1'b1; wt(8);
        do_init();
        chk("R1 init line", 32'(req_line), 0);
        iack_in = 1'b1; wt(8);
        chk("R1 init forwards", 32'(iack_out), 1);
        chk("R1 init no reply", 32'(reply), 0);
        iack_in = 1'b0; rd_strobe = 1'b0; wt(6);

        summary();
    end

endmodule